// File: doc/BRIEF.md
# Power-of-Two Column Scaler

This block takes one column of a complex matrix, presented as eight complex fixed-point entries (sixteen signed real components), and multiplies every component by one common power of two. The factor is chosen so that the largest absolute real or imaginary value in the column ends up between 2^LO_EXP and 2^HI_EXP. It sits in front of each orthogonalization step of a Gram-Schmidt style QR decomposition. In that decomposition only the orthonormal factor is used, so rescaling a whole column by one factor leaves the result unchanged, and the working values stay in the upper part of the fixed-point range.

The shift is not found by repeated doubling or halving. The peak magnitude is computed in one cycle, and its leading-one position gives the whole shift in one step. A single barrel shift per component then applies it. One column is accepted on every cycle. The scaled column, the signed shift count and a zero-column flag come out two cycles later.

Top module: `col_pow2_scaler`

## Requirements
- R1: Component k of a column sits at bits [k*DATA_W +: DATA_W] of `colIn` and of `colOut`. Even k is the real part and odd k the imaginary part of entry k/2. All components are signed two's complement.
- R2: The peak is the largest absolute value over all 2*NUM_CPLX components, including the last imaginary one. The magnitude of the most negative code is 2^(DATA_W-1).
- R3: If the peak p is nonzero and below 2^LO_EXP, the column is shifted left by LO_EXP - floor(log2 p), and `shiftCount` reports that positive number.
- R4: If p is above 2^HI_EXP, the column is shifted right by the smallest k with p <= 2^(HI_EXP+k), and `shiftCount` reports -k.
- R5: If 2^LO_EXP <= p <= 2^HI_EXP, including both bounds, `shiftCount` is 0 and `colOut` equals `colIn`.
- R6: Right shifts round toward zero. For example, -7 shifted right by 1 gives -3.
- R7: An all-zero column gives `shiftCount` 0, `zeroFlag` 1 and an all-zero `colOut`. Every nonzero column gives `zeroFlag` 0.
- R8: A column presented with `inValid` high at a rising edge appears with `outValid` high for one cycle after the second following edge. Columns may arrive on back-to-back cycles.
- R9: While reset is asserted, `outValid`, `shiftCount` and `zeroFlag` are 0.
- R10: `shiftCount` is signed with AMT_W+1 bits and positive for left shifts. It lies in [-(DATA_W-1-HI_EXP), LO_EXP].
- R11: For every nonzero column, the peak of `colOut` lies in [2^LO_EXP, 2^HI_EXP].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input column valid |
| colIn | input | 2*NUM_CPLX*DATA_W | Input column, packed as in R1 |
| outValid | output | 1 | Output column valid |
| colOut | output | 2*NUM_CPLX*DATA_W | Scaled column, packed as in R1 |
| shiftCount | output | AMT_W+1 | Signed applied shift, positive means left |
| zeroFlag | output | 1 | Column was all zero |

## Verification
Two situations are hard to reach from the ports. The first is the boundary of the right-shift rule, where the peak is an exact power of two or one code above it. Only there does the shift amount depend on the lower bits of the peak. The second is the most negative code, whose magnitude needs the full unsigned width. Directed columns are built around these cases: peaks of exactly 2^HI_EXP, 2^HI_EXP+1, 2^LO_EXP and 2^LO_EXP-1, and a column holding the most negative value. The peak is placed in the last imaginary slot so that the full reduction is exercised. A burst of three back-to-back columns with different shift directions checks that each output pairs with its own shift count.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  // width of an unsigned shift amount; supports data widths up to 31 bits
  localparam int AMT_W = 5;

  typedef struct packed {
    logic             loadEn;    // capture input column and its peak
    logic             outEn;     // capture shifted column
    logic             shiftLeft; // direction of the barrel shift
    logic [AMT_W-1:0] shiftAmt;  // magnitude of the barrel shift
  } scaleStrobes_t;
endpackage

// File: rtl/scaler_datapath.sv
module scaler_datapath
  import scaler_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_COMP = 16,
  parameter int MAX_LEFT = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  scaleStrobes_t              strobes,
  input  logic [NUM_COMP*DATA_W-1:0] colIn,
  output logic [DATA_W-1:0]          peakMag,
  output logic [NUM_COMP*DATA_W-1:0] colOut
);
  localparam int WIDE_W = DATA_W + MAX_LEFT;
  localparam logic signed [WIDE_W-1:0] MAX_POS = WIDE_W'((1 << (DATA_W-1)) - 1);
  localparam logic signed [WIDE_W-1:0] MIN_NEG = -(WIDE_W'(1 << (DATA_W-1)));

  logic [DATA_W-1:0]          absVal [NUM_COMP];
  logic [DATA_W-1:0]          peakNext;
  logic [NUM_COMP*DATA_W-1:0] colHeld;
  logic [DATA_W-1:0]          peakHeld;
  logic [NUM_COMP*DATA_W-1:0] colScaled;

  // magnitude of each incoming component, full unsigned width
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_abs
    logic signed [DATA_W:0] ext;
    logic signed [DATA_W:0] neg;
    assign ext = {colIn[k*DATA_W+DATA_W-1], colIn[k*DATA_W +: DATA_W]};
    assign neg = -ext;
    assign absVal[k] = ext[DATA_W] ? neg[DATA_W-1:0] : ext[DATA_W-1:0];
  end

  always_comb begin
    peakNext = '0;
    for (int k = 0; k < NUM_COMP; k++) begin
      if (absVal[k] > peakNext) peakNext = absVal[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colHeld  <= '0;
      peakHeld <= '0;
    end else if (strobes.loadEn) begin
      colHeld  <= colIn;
      peakHeld <= peakNext;
    end
  end

  assign peakMag = peakHeld;

  // one barrel shifter per component
  for (genvar k = 0; k < NUM_COMP; k++) begin : g_shift
    logic signed [DATA_W-1:0] x;
    logic signed [WIDE_W-1:0] wideX;
    logic signed [WIDE_W-1:0] leftRes;
    logic        [DATA_W:0]   magX;
    logic        [DATA_W:0]   magShr;
    logic        [DATA_W:0]   rightRes;
    logic signed [DATA_W-1:0] res;

    assign x       = colHeld[k*DATA_W +: DATA_W];
    assign wideX   = {{MAX_LEFT{x[DATA_W-1]}}, x};
    assign leftRes = wideX <<< strobes.shiftAmt;
    assign magX    = x[DATA_W-1] ? -{x[DATA_W-1], x} : {1'b0, x};
    assign magShr  = magX >> strobes.shiftAmt;
    assign rightRes = x[DATA_W-1] ? -magShr : magShr;

    always_comb begin
      if (strobes.shiftLeft) begin
        if (leftRes > MAX_POS)      res = MAX_POS[DATA_W-1:0];
        else if (leftRes < MIN_NEG) res = MIN_NEG[DATA_W-1:0];
        else                        res = leftRes[DATA_W-1:0];
      end else begin
        res = rightRes[DATA_W-1:0];
      end
    end

    assign colScaled[k*DATA_W +: DATA_W] = res;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              colOut <= '0;
    else if (strobes.outEn) colOut <= colScaled;
  end
endmodule

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import scaler_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LO_EXP = 8,
  parameter int HI_EXP = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [DATA_W-1:0]       peakMag,
  output scaleStrobes_t           strobes,
  output logic                    outValid,
  output logic signed [AMT_W:0]   shiftCount,
  output logic                    zeroFlag
);
  localparam logic [DATA_W-1:0] LO_BOUND = DATA_W'(1) << LO_EXP;
  localparam logic [DATA_W-1:0] HI_BOUND = DATA_W'(1) << HI_EXP;

  logic             stage1Valid;
  logic [AMT_W-1:0] msbPos;
  logic             isPow2;
  logic             isZero;
  logic             goLeft;
  logic [AMT_W-1:0] amt;
  logic signed [AMT_W:0] signedAmt;

  // leading-one position of the peak
  always_comb begin
    msbPos = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (peakMag[i]) msbPos = AMT_W'(i);
    end
  end

  assign isPow2 = (peakMag & (peakMag - DATA_W'(1))) == '0;
  assign isZero = peakMag == '0;

  always_comb begin
    goLeft = 1'b0;
    amt    = '0;
    if (!isZero && peakMag < LO_BOUND) begin
      goLeft = 1'b1;
      amt    = AMT_W'(LO_EXP) - msbPos;
    end else if (peakMag > HI_BOUND) begin
      amt = msbPos - AMT_W'(HI_EXP) + (isPow2 ? AMT_W'(0) : AMT_W'(1));
    end
  end

  assign signedAmt = goLeft ? $signed({1'b0, amt}) : -$signed({1'b0, amt});

  assign strobes.loadEn    = inValid;
  assign strobes.outEn     = stage1Valid;
  assign strobes.shiftLeft = goLeft;
  assign strobes.shiftAmt  = amt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
      shiftCount  <= '0;
      zeroFlag    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
      if (stage1Valid) begin
        shiftCount <= signedAmt;
        zeroFlag   <= isZero;
      end
    end
  end
endmodule

// File: rtl/col_pow2_scaler.sv
module col_pow2_scaler
  import scaler_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_CPLX = 8,
  parameter int LO_EXP   = 8,
  parameter int HI_EXP   = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [2*NUM_CPLX*DATA_W-1:0]   colIn,
  output logic                           outValid,
  output logic [2*NUM_CPLX*DATA_W-1:0]   colOut,
  output logic signed [AMT_W:0]          shiftCount,
  output logic                           zeroFlag
);
  localparam int NUM_COMP = 2 * NUM_CPLX;

  scaleStrobes_t     strobes;
  logic [DATA_W-1:0] peakMag;

  scaler_ctrl #(
    .DATA_W(DATA_W), .LO_EXP(LO_EXP), .HI_EXP(HI_EXP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .peakMag(peakMag),
    .strobes(strobes), .outValid(outValid), .shiftCount(shiftCount),
    .zeroFlag(zeroFlag)
  );

  scaler_datapath #(
    .DATA_W(DATA_W), .NUM_COMP(NUM_COMP), .MAX_LEFT(LO_EXP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .colIn(colIn),
    .peakMag(peakMag), .colOut(colOut)
  );
endmodule

// File: rtl/scaler_chk.sv
module scaler_chk
  import scaler_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_CPLX = 8,
  parameter int LO_EXP   = 8,
  parameter int HI_EXP   = 11
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         inValid,
  input logic                         outValid,
  input logic [2*NUM_CPLX*DATA_W-1:0] colOut,
  input logic signed [AMT_W:0]        shiftCount,
  input logic                         zeroFlag
);
  localparam int NUM_COMP = 2 * NUM_CPLX;
  logic [DATA_W:0] outPeak;

  always_comb begin
    outPeak = '0;
    for (int k = 0; k < NUM_COMP; k++) begin
      logic signed [DATA_W:0] v;
      logic        [DATA_W:0] a;
      v = {colOut[k*DATA_W+DATA_W-1], colOut[k*DATA_W +: DATA_W]};
      a = v[DATA_W] ? -v : v;
      if (a > outPeak) outPeak = a;
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R7
  zero_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zeroFlag) |-> (shiftCount == 0 && outPeak == 0));

  // R11
  window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !zeroFlag) |->
      (outPeak >= (DATA_W+1)'(1 << LO_EXP) && outPeak <= (DATA_W+1)'(1 << HI_EXP)));

  // R10
  shift_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (shiftCount <= LO_EXP && shiftCount >= -(DATA_W-1-HI_EXP)));
endmodule

bind col_pow2_scaler scaler_chk #(
  .DATA_W(DATA_W), .NUM_CPLX(NUM_CPLX), .LO_EXP(LO_EXP), .HI_EXP(HI_EXP)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .colOut(colOut), .shiftCount(shiftCount), .zeroFlag(zeroFlag)
);

// File: tb/col_pow2_scaler_bench.sv
module col_pow2_scaler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NC = 8;
  localparam int NK = 2 * NC;
  localparam int LO = 8;
  localparam int HI = 11;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [NK*DW-1:0] colIn = '0;
  logic             outValid;
  logic [NK*DW-1:0] colOut;
  logic signed [5:0] shiftCount;
  logic             zeroFlag;

  int checks = 0;
  int errors = 0;
  bit timedOut = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_pow2_scaler #(.DATA_W(DW), .NUM_CPLX(NC), .LO_EXP(LO), .HI_EXP(HI)) u_col_pow2_scaler (
    .clk(clk), .rstN(rstN), .inValid(inValid), .colIn(colIn),
    .outValid(outValid), .colOut(colOut), .shiftCount(shiftCount), .zeroFlag(zeroFlag)
  );

  typedef int col_t [NK];

  function automatic int peakOf(col_t c);
    int p = 0;
    for (int k = 0; k < NK; k++) begin
      int a = c[k] < 0 ? -c[k] : c[k];
      if (a > p) p = a;
    end
    return p;
  endfunction

  function automatic int refShift(col_t c);
    int p = peakOf(c);
    int msb = 0;
    int k = 0;
    if (p == 0) return 0;
    for (int i = 0; i < 31; i++) if ((p >> i) & 1) msb = i;
    if (p < (1 << LO)) return LO - msb;
    while (p > ((1 << HI) << k)) k++;
    return -k;
  endfunction

  function automatic int refComp(int x, int s);
    if (s >= 0) return x * (1 << s);
    return x / (1 << (-s)); // integer division truncates toward zero
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(col_t c);
    for (int k = 0; k < NK; k++) colIn[k*DW +: DW] = c[k][DW-1:0];
    inValid = 1'b1;
  endtask

  task automatic checkOut(col_t c, string req);
    int s = refShift(c);
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    check("R8", "outValid", int'(outValid), 1);
    check(req, "shiftCount", int'(shiftCount), s);
    check("R7", "zeroFlag", int'(zeroFlag), peakOf(c) == 0 ? 1 : 0);
    for (int k = 0; k < NK; k++) begin
      int act = int'($signed(colOut[k*DW +: DW]));
      int exp = refComp(c[k], s);
      if (act != exp && bad == 0) begin
        firstAct = act;
        firstExp = exp;
      end
      if (act != exp) bad++;
    end
    check({req, "/R1"}, "first mismatching component", firstAct, firstExp);
  endtask

  task automatic runCol(col_t c, string req);
    @(negedge clk); drive(c);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk); checkOut(c, req);
    @(negedge clk); check("R8", "outValid single pulse", int'(outValid), 0);
  endtask

  function automatic col_t fill(int v);
    col_t c;
    for (int k = 0; k < NK; k++) c[k] = (k % 2 == 0) ? v : -v;
    return c;
  endfunction

  task automatic testReset();
    @(negedge clk);
    check("R9", "outValid in reset", int'(outValid), 0);
    check("R9", "shiftCount in reset", int'(shiftCount), 0);
    check("R9", "zeroFlag in reset", int'(zeroFlag), 0);
  endtask

  task automatic testInWindow();
    col_t c = fill(300);
    c[3] = 1500; c[8] = -1024;
    runCol(c, "R5");
    c = fill(2048); runCol(c, "R5"); // upper bound exact
    c = fill(256);  runCol(c, "R5"); // lower bound exact
  endtask

  task automatic testSmall();
    col_t c = fill(0);
    c[0] = 5; c[1] = -3; c[6] = 1; c[9] = -4;
    runCol(c, "R3"); // peak 5 -> shift 6
    c = fill(255); runCol(c, "R3"); // just below lower bound -> shift 1
    c = fill(0); c[15] = -1; runCol(c, "R2"); // lone peak in last imaginary slot -> shift 8
  endtask

  task automatic testLarge();
    col_t c = fill(100);
    c[4] = -32768; c[5] = 32767;
    runCol(c, "R4"); // peak 2^15 -> shift -4
    c = fill(2049); c[7] = -7; c[2] = -2049;
    runCol(c, "R6"); // peak 2^11+1 -> shift -1, -7 -> -3
    c = fill(4097); c[11] = -4099;
    runCol(c, "R4"); // peak just above 2^12 -> shift -2
  endtask

  task automatic testZero();
    col_t c = fill(0);
    runCol(c, "R7");
  endtask

  task automatic testBurst();
    col_t a = fill(3);
    col_t b = fill(20000);
    col_t d = fill(700);
    @(negedge clk); drive(a);
    @(negedge clk); drive(b);
    @(negedge clk); checkOut(a, "R8"); drive(d);
    @(negedge clk); checkOut(b, "R8"); inValid = 1'b0;
    @(negedge clk); checkOut(d, "R8");
    @(negedge clk); check("R8", "burst end", int'(outValid), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1'b1;
        testInWindow();
        testSmall();
        testLarge();
        testZero();
        testBurst();
      end
      begin
        repeat (5000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule